// File: doc/BRIEF.md
# Voltage/Frequency Operating Point Sequencer

This controller moves a processor core between a fixed set of seven supply-voltage and clock-frequency pairs. An external workload filter asks for a performance level as a point index. The block then drives a voltage-select code toward the supply regulator and a frequency-select code toward the clock generator. It changes only one of the two codes at a time and holds each change for a programmable settling interval. This keeps the clock from running faster than the present supply can carry.

The seven points are listed here by index. Higher indices mean higher voltage and higher frequency.

| Index | Voltage | Frequency |
|---|---|---|
| 0 | 0.80 V | 300 MHz |
| 1 | 0.87 V | 433 MHz |
| 2 | 0.95 V | 533 MHz |
| 3 | 1.05 V | 667 MHz |
| 4 | 1.15 V | 800 MHz |
| 5 | 1.25 V | 900 MHz |
| 6 | 1.30 V | 1000 MHz |

Both select codes carry these indices directly, so no voltage/frequency pair outside the table can be requested. The settling interval is a cycle count. About 150 µs of settling corresponds to 18750 cycles at 125 MHz.

Top module: `dvs_sequencer`

## Requirements
- R1: After reset, `vsel` = 0, `fsel` = 0 and `busy` = 0.
- R2: At every clock, `fsel` is less than or equal to `vsel`. The codes are the point indices 0 to 6 from the table above.
- R3: Neither code ever exceeds 6. A request with `req_idx` of 7 is treated as a request for point 6.
- R4: Raising the point happens in two steps. First `vsel` moves to the target. Exactly `SETTLE_CYCLES` clocks later, `fsel` moves to the target.
- R5: Lowering the point happens in two steps. First `fsel` moves to the target. Exactly `SETTLE_CYCLES` clocks later, `vsel` moves to the target.
- R6: A request sampled at clock edge k produces the first step at edge k+1. `busy` is high from that step until `SETTLE_CYCLES` clocks after the second step, which is 2×`SETTLE_CYCLES` cycles in all. Whenever `busy` is low, `vsel` equals `fsel`.
- R7: A request that arrives while `busy` is high is held. Only the most recent one is kept. It is carried out after the current transition finishes.
- R8: A request for the point already in use has no effect: `busy` stays low and both codes stay unchanged.
- R9: A code changes only on a cycle where `busy` is high. At most one of the two codes changes at any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe from the workload filter |
| req_idx | input | IDX_W | Requested point index. Values above 6 are clamped. |
| vsel | output | IDX_W | Voltage-select code to the regulator |
| fsel | output | IDX_W | Frequency-select code to the clock generator |
| busy | output | 1 | High while a transition is in progress |

## Verification
A wrong transition state would show up at the ports in one of three ways. The codes could change in the wrong order, a step could come a cycle early or late relative to the settle count, or `fsel` could rise above `vsel` while a transition is in progress. The scoreboard records every code change together with the cycle gap from the previous change. An ordering or timing error is therefore reported at the first step that goes wrong. A lost or stale held request instead shows up as a missing or extra code change, and it is reported when the queue is drained at the end of the pending-request sequence.

// File: rtl/dvs_sequencer.sv
module dvs_sequencer #(
  parameter int NUM_PTS       = 7,
  parameter int SETTLE_CYCLES = 18750,
  parameter int IDX_W         = $clog2(NUM_PTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  output logic [IDX_W-1:0] vsel,
  output logic [IDX_W-1:0] fsel,
  output logic             busy
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_PTS - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] vsel_q, fsel_q, tgt, pend_idx, req_clamped;
  logic             pend_vld, going_up;

  assign req_clamped = (req_idx > TOP_IDX) ? TOP_IDX : req_idx;
  assign vsel = vsel_q;
  assign fsel = fsel_q;
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      vsel_q   <= '0;
      fsel_q   <= '0;
      tgt      <= '0;
      going_up <= 1'b0;
      pend_vld <= 1'b0;
      pend_idx <= '0;
    end else begin
      if (req_valid) begin
        pend_vld <= 1'b1;
        pend_idx <= req_clamped;
      end
      case (state)
        S_IDLE: begin
          if (pend_vld) begin
            if (!req_valid) pend_vld <= 1'b0;
            tgt <= pend_idx;
            cnt <= CNT_LOAD;
            if (pend_idx > vsel_q) begin
              vsel_q   <= pend_idx;
              going_up <= 1'b1;
              state    <= S_FIRST;
            end else if (pend_idx < vsel_q) begin
              fsel_q   <= pend_idx;
              going_up <= 1'b0;
              state    <= S_FIRST;
            end
          end
        end
        S_FIRST: begin
          if (cnt == '0) begin
            if (going_up) fsel_q <= tgt;
            else          vsel_q <= tgt;
            cnt   <= CNT_LOAD;
            state <= S_SECOND;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_SECOND: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dvs_sequencer_chk.sv
module dvs_sequencer_chk #(
  parameter int IDX_W   = 3,
  parameter int TOP_PT  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] vsel,
  input logic [IDX_W-1:0] fsel,
  input logic             busy
);

  p_freq_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fsel <= vsel);

  p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vsel <= IDX_W'(TOP_PT)) && (fsel <= IDX_W'(TOP_PT)));

  p_up_volt_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && (vsel > $past(vsel))) |-> (fsel == $past(fsel)));

  p_down_freq_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && (fsel < $past(fsel))) |-> (vsel == $past(vsel)));

  p_idle_matched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (vsel == fsel));

  p_one_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !((vsel != $past(vsel)) && (fsel != $past(fsel))));

  p_change_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((vsel != $past(vsel)) || (fsel != $past(fsel))) |-> busy);

endmodule

bind dvs_sequencer dvs_sequencer_chk #(.IDX_W(IDX_W), .TOP_PT(NUM_PTS - 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsel(vsel), .fsel(fsel), .busy(busy)
);

// File: tb/test_dvs_sequencer.sv
`timescale 1ns/1ps
module test_dvs_sequencer;
  localparam int S = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_idx = '0;
  logic [2:0] vsel, fsel;
  logic       busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  int model_pt = 0;

  typedef struct { logic [2:0] v; logic [2:0] f; int gap; string tag; } item_t;
  item_t exp_q[$];

  always #4 clk = ~clk;

  dvs_sequencer #(.NUM_PTS(7), .SETTLE_CYCLES(S)) i_dvs_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .vsel(vsel), .fsel(fsel), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Push the expected code changes for a move to point p.
  task automatic expect_move(input int p, input string tag);
    int t = (p > 6) ? 6 : p;
    if (t > model_pt) begin
      exp_q.push_back('{v: 3'(t), f: 3'(model_pt), gap: -1, tag: tag});
      exp_q.push_back('{v: 3'(t), f: 3'(t), gap: S, tag: tag});
    end else if (t < model_pt) begin
      exp_q.push_back('{v: 3'(model_pt), f: 3'(t), gap: -1, tag: tag});
      exp_q.push_back('{v: 3'(t), f: 3'(t), gap: S, tag: tag});
    end
    model_pt = t;
  endtask

  task automatic pulse(input int p);
    @(negedge clk);
    req_valid = 1'b1;
    req_idx = 3'(p);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic go(input int p, input string tag);
    int n;
    int prev = model_pt;
    expect_move(p, tag);
    pulse(p);
    @(negedge clk);
    if (prev == model_pt) begin
      check(busy == 1'b0, {tag, " busy after ignored request"}, busy, 0);
      repeat (2 * S) @(negedge clk);
      check(busy == 1'b0 && vsel == 3'(prev) && fsel == 3'(prev),
            {tag, " codes after ignored request"}, vsel, prev);
    end else begin
      n = 0;
      while (busy && n < 4 * S) begin
        n++;
        @(negedge clk);
      end
      check(n == 2 * S, {tag, " R6 busy length"}, n, 2 * S);
      check(vsel == 3'(model_pt) && fsel == 3'(model_pt), {tag, " final codes"}, fsel, model_pt);
    end
  endtask

  // Monitor: pops one expected item per observed code change.
  initial begin
    logic [2:0] lv = '0;
    logic [2:0] lf = '0;
    int last_chg = 0;
    item_t it;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && (vsel != lv || fsel != lf)) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected code change", {vsel, fsel}, {lv, lf});
        end else begin
          it = exp_q.pop_front();
          check(vsel == it.v && fsel == it.f, {it.tag, " step codes v/f"}, {vsel, fsel}, {it.v, it.f});
          if (it.gap >= 0)
            check(cyc - last_chg == it.gap, {it.tag, " settle gap"}, cyc - last_chg, it.gap);
        end
        lv = vsel;
        lf = fsel;
        last_chg = cyc;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(vsel == 0 && fsel == 0 && busy == 0, "R1 reset state", {vsel, fsel, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(vsel == 0 && fsel == 0 && busy == 0, "R1 after release", {vsel, fsel, busy}, 0);

    go(3, "R4 up 0->3");
    go(1, "R5 down 3->1");
    go(1, "R8 same 1");
    go(6, "R4 up 1->6");
    go(0, "R5 down 6->0");
    go(7, "R3 clamp 7->6");
    go(6, "R8 same 6");

    // R7: two requests during a transition; only the later one is applied
    expect_move(2, "R7 first");
    pulse(2);
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R7 busy during transition", busy, 1);
    pulse(4);
    pulse(5);
    expect_move(5, "R7 latest held");
    repeat (4 * S + 12) @(negedge clk);
    check(busy == 1'b0 && vsel == 5 && fsel == 5, "R7 final point", vsel, 5);
    check(exp_q.size() == 0, "R7 all expected steps seen", exp_q.size(), 0);

    go(0, "R5 down 5->0");
    check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule